// File: doc/BRIEF.md
# Autonomous Periodic Wake-up Timer

The block produces a periodic interrupt request on its own, with no software action after it has been set up. It counts ticks from one of two sources: a free-running internal oscillator tick or a bus-clock tick. Each source arrives as a one-cycle enable pulse in the block's clock domain. When the programmed number of ticks has passed, the block sets a pending flag and starts the next period at once. The interrupt output is raised while the flag is pending and interrupts are allowed.

Software programs the block through a small synchronous write port. The tick source and the 12-bit period are locked while the timer runs. To change them, software first stops the timer, then rewrites them, then starts it again. When the bus-clock source is chosen and the bus clock is reported off, the count holds its value and carries on once the clock returns.

Top module: `auto_wake_timer`

## Requirements
- R1: The count advances only while the run bit is 1. Setting the run bit starts a fresh period from a count of zero, using the period value held at that moment.
- R2: Source select 0 counts `osc_tick` pulses and source select 1 counts `bus_tick` pulses. The other source has no effect.
- R3: A write to the source-select bit is ignored while the run bit is already 1.
- R4: A write to the period register is ignored while the run bit is already 1.
- R5: The pending flag sets on the tick that completes a period. A period lasts the period value plus one ticks, so 0 expires on every tick and 0xFFF after 4096 ticks.
- R6: `irq` is 1 only when the pending flag is 1 and the interrupt-allow bit is 1.
- R7: After an expiry the timer begins the next period by itself. Periods follow one another with no write in between.
- R8: With source select 1 and `bus_clk_on` low, the count holds its value. It resumes from that value when `bus_clk_on` returns high.
- R9: Writing 1 to bit 0 at address 2 clears the pending flag. If an expiry and such a clear fall in the same cycle, the flag stays set.
- R10: Clearing the run bit stops the timer and returns the count to zero. The pending flag keeps its value.
- R11: The register map is as follows. Address 0 holds the control bits: bit 0 is run, bit 1 is source select and bit 2 is interrupt allow. Address 1, bits 11:0, holds the period. Address 2, bit 0, is the flag clear. Reset leaves every field at 0, so the timer is stopped and `irq` and `pending` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 16 | Register write data |
| osc_tick | input | 1 | Internal oscillator tick, one cycle wide |
| bus_tick | input | 1 | Bus-clock tick, one cycle wide |
| bus_clk_on | input | 1 | High while the bus clock runs |
| pending | output | 1 | Pending expiry flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle the properties that hold at each edge. The source select and the period stay unchanged while the timer runs, and the count never passes the period. The count is zero while the timer is stopped and holds while the bus clock is off. Every expiry sets the flag. Only the bench's scenarios can show the period lengths counted in ticks, the choice between the two sources and the gating by the interrupt-allow bit. The same holds for a set beating a clear in one cycle and for the flag surviving a stop.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 16;
  localparam int PERIOD_W = 12;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_PERIOD = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = 2'd2;
  localparam int BIT_RUN = 0;
  localparam int BIT_SEL = 1;
  localparam int BIT_IE  = 2;
  typedef enum logic {SRC_OSC = 1'b0, SRC_BUS = 1'b1} src_e;
endpackage

// File: rtl/pit_regs.sv
module pit_regs
  import pit_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int PW = PERIOD_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          expire,
  output logic          run,
  output src_e          src,
  output logic          ie,
  output logic [PW-1:0] period,
  output logic          flag
);
  logic wr_ctrl, wr_per, wr_clr;
  assign wr_ctrl = wr_en && (wr_addr == ADDR_CTRL);
  assign wr_per  = wr_en && (wr_addr == ADDR_PERIOD);
  assign wr_clr  = wr_en && (wr_addr == ADDR_STATUS) && wr_data[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      run    <= 1'b0;
      src    <= SRC_OSC;
      ie     <= 1'b0;
      period <= '0;
      flag   <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        run <= wr_data[BIT_RUN];
        ie  <= wr_data[BIT_IE];
        if (!run) src <= src_e'(wr_data[BIT_SEL]);
      end
      if (wr_per && !run) period <= wr_data[PW-1:0];
      if (expire) flag <= 1'b1;
      else if (wr_clr) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/pit_tick_sel.sv
module pit_tick_sel
  import pit_pkg::*;
(
  input  src_e src,
  input  logic osc_tick,
  input  logic bus_tick,
  input  logic bus_clk_on,
  output logic tick
);
  always_comb begin
    unique case (src)
      SRC_BUS: tick = bus_tick && bus_clk_on;
      default: tick = osc_tick;
    endcase
  end
endmodule

// File: rtl/pit_counter.sv
module pit_counter #(
  parameter int PW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          tick,
  input  logic [PW-1:0] period,
  output logic [PW-1:0] cnt,
  output logic          expire
);
  logic at_end;
  assign at_end = (cnt == period);
  assign expire = run && tick && at_end;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick) cnt <= at_end ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/auto_wake_timer.sv
module auto_wake_timer
  import pit_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int PW = PERIOD_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          osc_tick,
  input  logic          bus_tick,
  input  logic          bus_clk_on,
  output logic          pending,
  output logic          irq
);
  logic          run, ie, tick, expire;
  src_e          src;
  logic [PW-1:0] period, cnt;

  pit_regs #(.AW(AW), .DW(DW), .PW(PW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .expire(expire), .run(run), .src(src), .ie(ie), .period(period), .flag(pending)
  );

  pit_tick_sel u_sel (
    .src(src), .osc_tick(osc_tick), .bus_tick(bus_tick),
    .bus_clk_on(bus_clk_on), .tick(tick)
  );

  pit_counter #(.PW(PW)) u_cnt (
    .clk(clk), .rst(rst), .run(run), .tick(tick), .period(period),
    .cnt(cnt), .expire(expire)
  );

  assign irq = pending && ie;
endmodule

// File: rtl/auto_wake_timer_chk.sv
module auto_wake_timer_chk #(
  parameter int PW = 12
) (
  input logic          clk,
  input logic          rst,
  input logic          run,
  input logic          src,
  input logic          bus_clk_on,
  input logic [PW-1:0] period,
  input logic [PW-1:0] cnt,
  input logic          expire,
  input logic          pending
);
  AST_SRC_LOCKED: assert property (@(posedge clk) disable iff (rst)
    $past(run) |-> $stable(src)); // R3
  AST_PERIOD_LOCKED: assert property (@(posedge clk) disable iff (rst)
    $past(run) |-> $stable(period)); // R4
  AST_FLAG_ON_EXPIRY: assert property (@(posedge clk) disable iff (rst)
    expire |=> pending); // R5
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt <= period)); // R7
  AST_STOPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt == '0)); // R10
  AST_BUS_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (run && src && !bus_clk_on) |=> (!run || $stable(cnt))); // R8
endmodule

bind auto_wake_timer auto_wake_timer_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst(rst), .run(run), .src(src), .bus_clk_on(bus_clk_on),
  .period(period), .cnt(cnt), .expire(expire), .pending(pending)
);

// File: tb/auto_wake_timer_test.sv
module auto_wake_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {source select, period value}
  localparam logic [12:0] VEC [NVEC] = '{
    {1'b0, 12'd0}, {1'b0, 12'd3}, {1'b1, 12'd7},
    {1'b1, 12'd1}, {1'b0, 12'd15}, {1'b0, 12'hFFF}
  };

  logic clk = 0, rst = 1, wr_en = 0, osc_tick = 0, bus_tick = 0, bus_clk_on = 1;
  logic [1:0]  wr_addr = 0;
  logic [15:0] wr_data = 0;
  logic pending, irq;
  int checks = 0, fails = 0;

  auto_wake_timer uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .osc_tick(osc_tick), .bus_tick(bus_tick), .bus_clk_on(bus_clk_on),
    .pending(pending), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic pulse(input bit bus);
    @(negedge clk); if (bus) bus_tick = 1; else osc_tick = 1;
    @(negedge clk); bus_tick = 0; osc_tick = 0;
  endtask

  task automatic pulses(input bit bus, input int n);
    for (int i = 0; i < n; i++) pulse(bus);
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R11 reset pending", pending, 0);
    check("R11 reset irq", irq, 0);

    // Vector table: period length in ticks on each source (R2, R5)
    for (int v = 0; v < NVEC; v++) begin
      int n;
      logic sel;
      sel = VEC[v][12];
      wr(0, 16'h0); wr(2, 16'h1);
      wr(1, {4'h0, VEC[v][11:0]});
      wr(0, {13'h0, 1'b1, sel, 1'b0});
      wr(0, {13'h0, 1'b1, sel, 1'b1});
      n = 0;
      while (!pending && n < 5000) begin pulse(sel); n++; end
      check("R5 R2 ticks to expiry", n, int'(VEC[v][11:0]) + 1);
      check("R6 irq with allow", irq, 1);
    end

    // R2: wrong source ignored; R3: source change while running ignored
    wr(0, 0); wr(2, 1); wr(1, 2); wr(0, 16'h1);
    wr(0, 16'h3);
    pulses(1, 5);
    check("R3 R2 bus ticks ignored", pending, 0);
    pulses(0, 3);
    check("R3 osc source kept", pending, 1);

    // R4: period write while running ignored; R7 auto restart
    wr(2, 1); wr(1, 9);
    pulses(0, 3);
    check("R4 old period used", pending, 1);
    wr(2, 1);
    check("R9 clear flag", pending, 0);
    pulses(0, 2);
    check("R7 mid second period", pending, 0);
    pulses(0, 1);
    check("R7 second period expiry", pending, 1);

    // R6: allow bit gates irq
    wr(0, 16'h1);
    check("R6 irq blocked", irq, 0);
    check("R6 flag still set", pending, 1);
    wr(0, 16'h5);
    check("R6 irq raised", irq, 1);

    // R10: stop resets count, keeps flag
    wr(0, 0);
    check("R10 flag kept on stop", pending, 1);
    wr(2, 1); wr(1, 3); wr(0, 16'h1);
    pulses(0, 2);
    wr(0, 0); wr(0, 16'h1);
    pulses(0, 3);
    check("R10 R1 count restarted", pending, 0);
    pulses(0, 1);
    check("R10 R1 full period after restart", pending, 1);

    // R1: no counting while stopped
    wr(0, 0); wr(2, 1);
    pulses(0, 10);
    check("R1 stopped no flag", pending, 0);

    // R8: freeze while bus clock off
    wr(0, 16'h2); wr(1, 3); wr(0, 16'h3);
    pulses(1, 2);
    bus_clk_on = 0;
    pulses(1, 5);
    check("R8 frozen", pending, 0);
    bus_clk_on = 1;
    pulses(1, 1);
    check("R8 resumed not yet", pending, 0);
    pulses(1, 1);
    check("R8 resumed expiry", pending, 1);

    // R9: set beats clear in the same cycle
    wr(0, 0); wr(1, 0); wr(0, 16'h1);
    pulses(0, 1);
    check("R9 pre flag", pending, 1);
    @(negedge clk); osc_tick = 1; wr_en = 1; wr_addr = 2; wr_data = 1;
    @(negedge clk); osc_tick = 0; wr_en = 0;
    check("R9 set wins", pending, 1);
    wr(2, 16'h0);
    check("R9 write zero keeps", pending, 1);
    wr(2, 16'h1);
    check("R9 clear", pending, 0);

    rst = 1; @(negedge clk); rst = 0; @(negedge clk);
    check("R11 reset again", pending, 0);
    summary();
  end
endmodule